// File: doc/BRIEF.md
# Trace Resume Exception Placeholder Injector

This block sits between the retirement side of a processor and a trace packet formatter. It passes retired-instruction events from its input stream to its output stream. It also watches the trace-enable condition, which is made of a software enable, a debug-state flag and a prohibited-region flag. When trace stops, the block notes whether the stop was automatic (debug state or a prohibited region, with the enable still high) or deliberate (the enable was low).

The first traced instruction after an automatic gap may be the instruction at an exception vector. Without help, the formatter would lose that exception, because an exception cannot be reported before the first traced instruction. In that case the block injects two events ahead of the vector instruction. The first is a placeholder instruction. The second is an exception branch event that carries the exception type and is marked as canceling. The vector instruction then follows as an ordinary instruction. Reset exceptions never cause this injection. After a deliberate stop or a reset of the block, an exception flagged on the first traced instruction is dropped.

Both streams use valid/ready handshaking. The output is driven from one register stage. The input is stalled while the two extra events are issued.

Top module: `trace_resume_injector`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid_o` is 0 and `in_ready_o` is 1.
- R2: Trace is active when `trc_en_i` is 1, `dbg_i` is 0 and `prohib_i` is 0. An input event accepted while trace is inactive is consumed and produces no output event.
- R3: An event accepted while trace is active appears on the output one cycle later as kind 2'b00 (instruction) with the same address. Output kind 2'b11 never occurs.
- R4: After reset, or after a gap whose last inactive cycle had `trc_en_i` at 0, the first traced instruction is output as kind 2'b00 with `out_exc_o` 0, even if `in_exc_i` is 1.
- R5: After a gap whose last inactive cycle had `trc_en_i` at 1, a first traced instruction with `in_exc_i` 1 and `in_exc_reset_i` 0 produces three events at the same address, in this order:
  - kind 2'b01 (placeholder) with all exception fields 0;
  - kind 2'b10 (exception branch) with `out_exc_o` 1, the input exception type, `out_cancel_o` 1, and slot-kill and data-abort copied from the input;
  - kind 2'b00 with `out_exc_o` 0.
- R6: With `out_ready_i` held at 1, the three events of R5 are issued on consecutive cycles, and `in_ready_o` is 0 for exactly the two cycles after the vector instruction is accepted.
- R7: A first traced instruction flagged as a reset exception (`in_exc_reset_i` 1) is never preceded by injected events. It is output as kind 2'b00 with `out_exc_o` 0.
- R8: The 3-bit exception type is carried unchanged. Its codes are 3'b001 normal interrupt, 3'b101 fast interrupt, 3'b100 bytecode-engine exception, 3'b110 precise data abort and 3'b000 any other exception.
- R9: On any output event whose `out_exc_o` is 0, the type, cancel, slot-kill and data-abort outputs are 0. The input qualifiers are ignored when `in_exc_i` is 0.
- R10: While `out_valid_o` is 1 and `out_ready_i` is 0, every output holds its value. No event is lost or duplicated under backpressure.
- R11: Once an instruction has been traced since the last gap, an instruction with `in_exc_i` 1 is passed as kind 2'b00 with `out_exc_o` 1. It carries its type, slot-kill, data-abort, and `out_cancel_o` equal to `in_xcancel_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trc_en_i | input | 1 | Software trace enable |
| dbg_i | input | 1 | Processor in debug state |
| prohib_i | input | 1 | Processor in a trace-prohibited region |
| in_valid_i | input | 1 | Input instruction event valid |
| in_ready_o | output | 1 | Input event accepted this cycle when valid |
| in_addr_i | input | AW | Instruction address |
| in_exc_i | input | 1 | Instruction is the first at an exception vector |
| in_exc_reset_i | input | 1 | The exception is a reset |
| in_etype_i | input | 3 | Exception type code |
| in_kill_i | input | 1 | Exception qualifier: kill outstanding slots |
| in_dabort_i | input | 1 | Exception qualifier: data abort |
| in_xcancel_i | input | 1 | Exception qualifier: previous instruction canceled |
| out_valid_o | output | 1 | Output event valid |
| out_ready_i | input | 1 | Formatter accepts output event |
| out_kind_o | output | 2 | 00 instruction, 01 placeholder, 10 exception branch |
| out_addr_o | output | AW | Event address |
| out_exc_o | output | 1 | Event reports an exception |
| out_etype_o | output | 3 | Exception type code |
| out_cancel_o | output | 1 | Exception canceled the preceding instruction |
| out_kill_o | output | 1 | Slot-kill qualifier |
| out_dabort_o | output | 1 | Data-abort qualifier |

## Verification
An event accepted at a clock edge appears on the output just after that edge.

For an injection with the formatter always ready, the placeholder, the exception branch and the vector instruction follow on three consecutive edges. `in_ready_o` stays low across the two edges in between. The bench samples `in_ready_o` one nanosecond after each falling edge to confirm this two-cycle stall.

Output events are recorded only at falling edges where valid and ready are both high. The recorded sequence is then compared, in order, with a list the bench builds from the gap kind and the input fields. Under random backpressure, a stalled output is compared with its value one cycle earlier.

// File: rtl/trr_pkg.sv
package trr_pkg;

    typedef enum logic [1:0] {
        EV_INSN  = 2'b00,
        EV_PLACE = 2'b01,
        EV_EXCBR = 2'b10
    } ev_kind_e;

    typedef struct packed {
        ev_kind_e   kind;
        logic       exc;
        logic [2:0] etype;
        logic       cancel;
        logic       kill;
        logic       dabort;
    } ev_meta_t;

    typedef enum logic [1:0] {
        SQ_PASS = 2'd0,
        SQ_EXC  = 2'd1,
        SQ_VEC  = 2'd2
    } sq_state_e;

    // Builds event metadata; qualifiers only survive when exc is set.
    function automatic ev_meta_t mk_meta(ev_kind_e k, logic exc, logic [2:0] et,
                                         logic cxl, logic kl, logic da);
        ev_meta_t m;
        m.kind   = k;
        m.exc    = exc;
        m.etype  = exc ? et : 3'b000;
        m.cancel = exc & cxl;
        m.kill   = exc & kl;
        m.dabort = exc & da;
        return m;
    endfunction

endpackage

// File: rtl/trr_gap_track.sv
module trr_gap_track (
    input  logic clk,
    input  logic rst_n,
    input  logic trc_en_i,
    input  logic dbg_i,
    input  logic prohib_i,
    input  logic mark_i,
    output logic active_o,
    output logic traced_o,
    output logic auto_stop_o
);
    typedef struct packed {
        logic traced;
        logic auto_stop;
    } gap_t;

    gap_t d, q;

    always_comb begin
        d        = q;
        active_o = trc_en_i & ~dbg_i & ~prohib_i;
        if (!active_o) begin
            // Any inactive cycle reopens the gap; the cause seen last is kept.
            d.traced    = 1'b0;
            d.auto_stop = trc_en_i;
        end else if (mark_i) begin
            d.traced = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign traced_o    = q.traced;
    assign auto_stop_o = q.auto_stop;

    // R2: a traced mark can never coexist with an inactive cycle.
    p_gap_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !active_o |=> !traced_o);

endmodule

// File: rtl/trr_seq.sv
module trr_seq #(
    parameter int AW = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  active_i,
    input  logic                  traced_i,
    input  logic                  auto_stop_i,
    input  logic                  can_load_i,
    input  logic                  in_valid_i,
    output logic                  in_ready_o,
    input  logic [AW-1:0]         in_addr_i,
    input  logic                  in_exc_i,
    input  logic                  in_exc_reset_i,
    input  logic [2:0]            in_etype_i,
    input  logic                  in_kill_i,
    input  logic                  in_dabort_i,
    input  logic                  in_xcancel_i,
    output logic                  load_o,
    output logic [AW-1:0]         ld_addr_o,
    output trr_pkg::ev_meta_t     ld_meta_o,
    output logic                  mark_o
);
    import trr_pkg::*;

    typedef struct packed {
        sq_state_e     st;
        logic [AW-1:0] addr;
        logic [2:0]    etype;
        logic          kill;
        logic          dabort;
    } seq_t;

    seq_t d, q;
    logic accept;
    logic inject;

    always_comb begin
        d          = q;
        in_ready_o = 1'b0;
        load_o     = 1'b0;
        mark_o     = 1'b0;
        ld_addr_o  = '0;
        ld_meta_o  = mk_meta(EV_INSN, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0);
        inject     = in_exc_i & ~in_exc_reset_i & ~traced_i & auto_stop_i;
        accept     = 1'b0;
        unique case (q.st)
            SQ_PASS: begin
                in_ready_o = can_load_i | ~active_i;
                accept     = in_valid_i & in_ready_o;
                if (accept && active_i) begin
                    mark_o    = 1'b1;
                    load_o    = 1'b1;
                    ld_addr_o = in_addr_i;
                    if (inject) begin
                        ld_meta_o = mk_meta(EV_PLACE, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0);
                        d.st      = SQ_EXC;
                        d.addr    = in_addr_i;
                        d.etype   = in_etype_i;
                        d.kill    = in_kill_i;
                        d.dabort  = in_dabort_i;
                    end else begin
                        // Exceptions are reportable only after a traced instruction.
                        ld_meta_o = mk_meta(EV_INSN, in_exc_i & traced_i, in_etype_i,
                                            in_xcancel_i, in_kill_i, in_dabort_i);
                    end
                end
            end
            SQ_EXC: begin
                if (can_load_i) begin
                    load_o    = 1'b1;
                    ld_addr_o = q.addr;
                    ld_meta_o = mk_meta(EV_EXCBR, 1'b1, q.etype, 1'b1, q.kill, q.dabort);
                    d.st      = SQ_VEC;
                end
            end
            SQ_VEC: begin
                if (can_load_i) begin
                    load_o    = 1'b1;
                    ld_addr_o = q.addr;
                    ld_meta_o = mk_meta(EV_INSN, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0);
                    d.st      = SQ_PASS;
                end
            end
            default: d.st = SQ_PASS;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st     <= SQ_PASS;
            q.addr   <= '0;
            q.etype  <= '0;
            q.kill   <= 1'b0;
            q.dabort <= 1'b0;
        end else begin
            q <= d;
        end
    end

    // R6: input held off for the whole of an injection.
    p_stall_inject_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && active_i && inject) |=> !in_ready_o);

    // R7: a reset exception never opens an injection.
    p_no_reset_inject_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_exc_reset_i) |=> (q.st == SQ_PASS));

endmodule

// File: rtl/trr_out_stage.sv
module trr_out_stage #(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [AW-1:0]     addr_i,
    input  trr_pkg::ev_meta_t meta_i,
    input  logic              out_ready_i,
    output logic              can_load_o,
    output logic              out_valid_o,
    output logic [AW-1:0]     out_addr_o,
    output trr_pkg::ev_meta_t out_meta_o
);
    import trr_pkg::*;

    typedef struct packed {
        logic          v;
        logic [AW-1:0] addr;
        ev_meta_t      meta;
    } ostg_t;

    ostg_t d, q;

    always_comb begin
        d          = q;
        can_load_o = ~q.v | out_ready_i;
        if (load_i) begin
            d.v    = 1'b1;
            d.addr = addr_i;
            d.meta = meta_i;
        end else if (out_ready_i) begin
            d.v = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.v    <= 1'b0;
            q.addr <= '0;
            q.meta <= mk_meta(EV_INSN, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0);
        end else begin
            q <= d;
        end
    end

    assign out_valid_o = q.v;
    assign out_addr_o  = q.addr;
    assign out_meta_o  = q.meta;

    // R10: a stalled event stays put.
    p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_addr_o) && $stable(out_meta_o)));

endmodule

// File: rtl/trace_resume_injector.sv
module trace_resume_injector #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trc_en_i,
    input  logic          dbg_i,
    input  logic          prohib_i,
    input  logic          in_valid_i,
    output logic          in_ready_o,
    input  logic [AW-1:0] in_addr_i,
    input  logic          in_exc_i,
    input  logic          in_exc_reset_i,
    input  logic [2:0]    in_etype_i,
    input  logic          in_kill_i,
    input  logic          in_dabort_i,
    input  logic          in_xcancel_i,
    output logic          out_valid_o,
    input  logic          out_ready_i,
    output logic [1:0]    out_kind_o,
    output logic [AW-1:0] out_addr_o,
    output logic          out_exc_o,
    output logic [2:0]    out_etype_o,
    output logic          out_cancel_o,
    output logic          out_kill_o,
    output logic          out_dabort_o
);
    import trr_pkg::*;

    logic          active, traced, auto_stop, mark;
    logic          can_load, load;
    logic [AW-1:0] ld_addr;
    ev_meta_t      ld_meta, o_meta;

    trr_gap_track u_gap (
        .clk         (clk),
        .rst_n       (rst_n),
        .trc_en_i    (trc_en_i),
        .dbg_i       (dbg_i),
        .prohib_i    (prohib_i),
        .mark_i      (mark),
        .active_o    (active),
        .traced_o    (traced),
        .auto_stop_o (auto_stop)
    );

    trr_seq #(.AW(AW)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .active_i       (active),
        .traced_i       (traced),
        .auto_stop_i    (auto_stop),
        .can_load_i     (can_load),
        .in_valid_i     (in_valid_i),
        .in_ready_o     (in_ready_o),
        .in_addr_i      (in_addr_i),
        .in_exc_i       (in_exc_i),
        .in_exc_reset_i (in_exc_reset_i),
        .in_etype_i     (in_etype_i),
        .in_kill_i      (in_kill_i),
        .in_dabort_i    (in_dabort_i),
        .in_xcancel_i   (in_xcancel_i),
        .load_o         (load),
        .ld_addr_o      (ld_addr),
        .ld_meta_o      (ld_meta),
        .mark_o         (mark)
    );

    trr_out_stage #(.AW(AW)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .addr_i      (ld_addr),
        .meta_i      (ld_meta),
        .out_ready_i (out_ready_i),
        .can_load_o  (can_load),
        .out_valid_o (out_valid_o),
        .out_addr_o  (out_addr_o),
        .out_meta_o  (o_meta)
    );

    assign out_kind_o   = o_meta.kind;
    assign out_exc_o    = o_meta.exc;
    assign out_etype_o  = o_meta.etype;
    assign out_cancel_o = o_meta.cancel;
    assign out_kill_o   = o_meta.kill;
    assign out_dabort_o = o_meta.dabort;

    // R2: an event swallowed during a gap leaves nothing on a drained output.
    p_drop_inactive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_ready_o && !(trc_en_i && !dbg_i && !prohib_i)
         && (!out_valid_o || out_ready_i)) |=> !out_valid_o);

    // R3: the reserved kind code never appears.
    p_legal_kind_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (out_kind_o != 2'b11));

    // R5: a taken placeholder is followed at once by a canceling exception branch.
    p_ph_then_exc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && out_ready_i && out_kind_o == 2'b01)
        |=> (out_valid_o && out_kind_o == 2'b10 && out_cancel_o && out_exc_o));

    // R5: a taken exception branch is followed by the vector instruction at its address.
    p_exc_then_vec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && out_ready_i && out_kind_o == 2'b10)
        |=> (out_valid_o && out_kind_o == 2'b00 && !out_exc_o && out_addr_o == $past(out_addr_o)));

    // R9: qualifiers are silent on events without an exception.
    p_qual_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_exc_o) |-> (!out_cancel_o && !out_kill_o && !out_dabort_o && out_etype_o == 3'b000));

endmodule

// File: tb/tb_trace_resume_injector.sv
`timescale 1ns/100ps
module tb_trace_resume_injector;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trc_en = 1'b1, dbg = 1'b0, prohib = 1'b0;
    logic in_valid = 1'b0, in_ready;
    logic [AW-1:0] in_addr = '0;
    logic in_exc = 1'b0, in_rst = 1'b0, in_kill = 1'b0, in_dab = 1'b0, in_xc = 1'b0;
    logic [2:0] in_et = '0;
    logic out_valid, out_ready = 1'b1;
    logic [1:0] out_kind;
    logic [AW-1:0] out_addr;
    logic out_exc, out_cancel, out_kill, out_dab;
    logic [2:0] out_et;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    trace_resume_injector #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .trc_en_i(trc_en), .dbg_i(dbg), .prohib_i(prohib),
        .in_valid_i(in_valid), .in_ready_o(in_ready), .in_addr_i(in_addr),
        .in_exc_i(in_exc), .in_exc_reset_i(in_rst), .in_etype_i(in_et),
        .in_kill_i(in_kill), .in_dabort_i(in_dab), .in_xcancel_i(in_xc),
        .out_valid_o(out_valid), .out_ready_i(out_ready), .out_kind_o(out_kind),
        .out_addr_o(out_addr), .out_exc_o(out_exc), .out_etype_o(out_et),
        .out_cancel_o(out_cancel), .out_kill_o(out_kill), .out_dabort_o(out_dab)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] pk(logic [1:0] k, logic e, logic [2:0] t, logic c,
                                       logic kl, logic d, logic [AW-1:0] a);
        return {23'd0, k, e, t, c, kl, d, a};
    endfunction

    logic [63:0] rec [0:63];
    logic [63:0] expv [0:63];
    int rec_n = 0, exp_n = 0;
    logic stall_prev = 1'b0;
    logic [63:0] stall_val = '0;

    // Output monitor, sampling 2 ns after each falling edge.
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (stall_prev)
                check(out_valid && pk(out_kind, out_exc, out_et, out_cancel, out_kill, out_dab, out_addr) == stall_val,
                      "R10 stalled output held",
                      pk(out_kind, out_exc, out_et, out_cancel, out_kill, out_dab, out_addr), stall_val);
            stall_prev = out_valid && !out_ready;
            stall_val  = pk(out_kind, out_exc, out_et, out_cancel, out_kill, out_dab, out_addr);
            if (out_valid && out_ready && rec_n < 64) begin
                rec[rec_n] = stall_val;
                rec_n++;
            end
        end
    end

    task automatic clear();
        rec_n = 0;
        exp_n = 0;
    endtask

    task automatic expect_ev(input logic [63:0] v);
        expv[exp_n] = v;
        exp_n++;
    endtask

    task automatic compare(input string req);
        check(rec_n == exp_n, {req, " event count"}, 64'(rec_n), 64'(exp_n));
        for (int i = 0; i < exp_n && i < rec_n; i++)
            check(rec[i] == expv[i], req, rec[i], expv[i]);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic gate(input logic e, input logic d, input logic p);
        @(negedge clk);
        trc_en = e; dbg = d; prohib = p;
    endtask

    task automatic send(input logic [AW-1:0] a, input logic ex, input logic rs, input logic [2:0] t,
                        input logic kl, input logic da, input logic xc);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a; in_exc = ex; in_rst = rs; in_et = t;
        in_kill = kl; in_dab = da; in_xc = xc;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state.
        idle(3);
        #1;
        check(!out_valid, "R1 out_valid in reset", 64'(out_valid), 0);
        check(in_ready, "R1 in_ready in reset", 64'(in_ready), 1);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(!out_valid && in_ready, "R1 after reset", {62'd0, out_valid, in_ready}, 64'd1);

        // R4: exception on the first instruction after reset is not reported.
        clear();
        send(32'h100, 1'b1, 1'b0, 3'b001, 1'b1, 1'b1, 1'b1);
        expect_ev(pk(2'b00, 0, 0, 0, 0, 0, 32'h100));
        // R9: qualifiers ignored without exception flag.
        send(32'h104, 1'b0, 1'b0, 3'b111, 1'b1, 1'b1, 1'b1);
        expect_ev(pk(2'b00, 0, 0, 0, 0, 0, 32'h104));
        // R11: later exception passes with its fields.
        send(32'h18, 1'b1, 1'b0, 3'b101, 1'b0, 1'b1, 1'b1);
        expect_ev(pk(2'b00, 1, 3'b101, 1, 0, 1, 32'h18));
        idle(3);
        compare("R4/R9/R11 post-reset stream");

        // R2: events during a gap are dropped.
        clear();
        gate(1'b1, 1'b1, 1'b0);
        send(32'h200, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0);
        send(32'h204, 1'b1, 1'b0, 3'b001, 1'b0, 1'b0, 1'b0);
        gate(1'b0, 1'b0, 1'b0);
        send(32'h208, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0);
        idle(3);
        compare("R2 dropped during gap");
        gate(1'b1, 1'b0, 1'b0);

        // R6: stall timing of an injection.
        gate(1'b1, 1'b0, 1'b1);
        gate(1'b1, 1'b0, 1'b0);
        clear();
        @(negedge clk);
        in_valid = 1'b1; in_addr = 32'h1C; in_exc = 1'b1; in_rst = 1'b0; in_et = 3'b110;
        in_kill = 1'b1; in_dab = 1'b0; in_xc = 1'b0;
        #1;
        check(in_ready, "R6 ready before accept", 64'(in_ready), 1);
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        check(!in_ready, "R6 stall cycle 1", 64'(in_ready), 0);
        @(negedge clk);
        #1;
        check(!in_ready, "R6 stall cycle 2", 64'(in_ready), 0);
        @(negedge clk);
        #1;
        check(in_ready, "R6 ready again", 64'(in_ready), 1);
        expect_ev(pk(2'b01, 0, 0, 0, 0, 0, 32'h1C));
        expect_ev(pk(2'b10, 1, 3'b110, 1, 1, 0, 32'h1C));
        expect_ev(pk(2'b00, 0, 0, 0, 0, 0, 32'h1C));
        idle(3);
        compare("R5/R6 injected sequence");

        // R5 R7 R8 R4 R11: sweep over gap causes, reset flag and all field values.
        for (int m = 0; m < 5; m++) begin
            for (int r = 0; r < 2; r++) begin
                for (int c = 0; c < 64; c++) begin
                    logic e, d, p, auto_gap;
                    logic [2:0] t;
                    logic kl, da, xc;
                    logic [AW-1:0] a;
                    e = (m != 3 && m != 4);
                    d = (m == 0 || m == 2 || m == 4);
                    p = (m == 1 || m == 2);
                    auto_gap = e && (d || p);
                    t = c[2:0]; kl = c[3]; da = c[4]; xc = c[5];
                    a = 32'h4000 + 32'((m * 128 + r * 64 + c) * 16);
                    clear();
                    gate(e, d, p);
                    gate(1'b1, 1'b0, 1'b0);
                    send(a, 1'b1, r[0], t, kl, da, xc);
                    send(a + 4, 1'b1, 1'b0, t, kl, da, xc);
                    idle(3);
                    if (auto_gap && r == 0) begin
                        expect_ev(pk(2'b01, 0, 0, 0, 0, 0, a));
                        expect_ev(pk(2'b10, 1, t, 1, kl, da, a));
                        expect_ev(pk(2'b00, 0, 0, 0, 0, 0, a));
                    end else begin
                        expect_ev(pk(2'b00, 0, 0, 0, 0, 0, a));
                    end
                    expect_ev(pk(2'b00, 1, t, xc, kl, da, a + 4));
                    if (r == 1)
                        compare("R7 reset exception no placeholder");
                    else if (auto_gap)
                        compare("R5/R8 injection after automatic gap");
                    else
                        compare("R4 no report after deliberate stop");
                end
            end
        end

        // R10: backpressure during injection.
        clear();
        gate(1'b1, 1'b1, 1'b0);
        gate(1'b1, 1'b0, 1'b0);
        fork
            send(32'hA0, 1'b1, 1'b0, 3'b100, 1'b0, 1'b1, 1'b0);
            for (int i = 0; i < 24; i++) begin
                @(negedge clk);
                out_ready = (i % 3 == 2);
            end
        join
        @(negedge clk);
        out_ready = 1'b1;
        idle(4);
        expect_ev(pk(2'b01, 0, 0, 0, 0, 0, 32'hA0));
        expect_ev(pk(2'b10, 1, 3'b100, 1, 0, 1, 32'hA0));
        expect_ev(pk(2'b00, 0, 0, 0, 0, 0, 32'hA0));
        compare("R10 sequence under backpressure");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule